// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

This block collects up to eight interrupt request lines, keeps a pending register, an in-service register and a mask register, and chooses among the unmasked pending requests with a fixed priority in which input 0 wins. When a request may be forwarded it raises `irq_out`. The processor side answers with a one-cycle `irq_ack` pulse. The cycle after that, the block presents an 8-bit vector on `vec_out` together with `vec_valid`. It moves the winning request into service at the same time, unless automatic end-of-interrupt is selected.

Software programs the block through a byte-wide register port with one address line. A write to address 0 with bit 4 set opens an ordered sequence of setup words, and the words that follow go to address 1. Once setup is done, address 1 holds the mask. Address 0 takes command bytes that end service on a level or select which register a read of address 0 returns. The controller states are RUN (normal operation), plus three setup states: WAIT_BASE, WAIT_CASC and WAIT_MODE. The transitions are:

- A start word leads from any state to WAIT_BASE.
- From WAIT_BASE, a base write goes to WAIT_CASC, to WAIT_MODE, or straight to RUN, depending on the flags the start word carried.
- From WAIT_CASC, a cascade write goes to WAIT_MODE or to RUN.
- From WAIT_MODE, a mode write goes to RUN.

Top module: `pic_core`

## Requirements
- R1: After reset the mask reads 0xFF, pending and in-service are empty, `irq_out` is low, and a read of address 0 returns the pending register.
- R2: A write to address 0 with bit 4 set starts setup. It sets the mask to 0xFF, clears pending and in-service, and selects pending for readback. The start word's bit 3 selects level sensing, bit 1 skips the cascade word and bit 0 requests the mode word. The next address-1 writes are taken as base, then cascade (stored) if not skipped, then mode if requested. After that, address-1 writes load the mask.
- R3: An `irq_ack` pulse in RUN yields `vec_valid` high for exactly the following cycle, with `vec_out` = {base bits 7..3, winning level}.
- R4: An address-1 write in RUN loads the mask. A 1 bit blocks that input, and a read of address 1 returns the mask.
- R5: Level 0 has the highest priority. A pending unmasked level is forwarded only if no level of equal or higher priority is in service.
- R6: Writing 0x0A to address 0 makes later address-0 reads return pending, and writing 0x0B makes them return in-service. The choice persists until changed.
- R7: Writing 0x60+n to address 0 clears only in-service bit n.
- R8: Writing 0x20 to address 0 clears the highest-priority in-service bit.
- R9: With mode word bit 1 set (automatic end-of-interrupt), an acknowledge leaves in-service unchanged. A setup without a mode word turns this off.
- R10: An acknowledge with no forwardable request returns base+7 and leaves in-service unchanged, even if input 7 is masked.
- R11: In edge mode a pending bit is set by a rising input and needs a new rising edge after acknowledge or setup. In level mode it is set while the input is high. In both modes it clears when the input falls.
- R12: During setup `irq_out` stays low and `irq_ack` produces no vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_rdata | output | 8 | Read data, combinational |
| irq_in | input | 8 | Interrupt request lines |
| irq_out | output | 1 | Interrupt request to the processor |
| irq_ack | input | 1 | Acknowledge pulse |
| vec_valid | output | 1 | Vector present, one cycle after acknowledge |
| vec_out | output | 8 | Vector |

## Verification
The bench targets three areas:

- **Priority blocking.** A lower request must wait behind an in-service level, then appear once that level is ended by a specific or a non-specific command. A design with an inverted or inclusive comparison would forward it early or never.
- **The vanished request.** An input drops after `irq_out` rose and is then acknowledged with input 7 masked. A faulty design would return a stale level or set an in-service bit.
- **Setup.** The bench runs the full four-word sequence, a two-word sequence with the cascade and mode words skipped, and an acknowledge during setup. It also checks that a held input is not re-requested in edge mode and is re-requested in level mode. A design that skipped a word wrongly would load the mask with a setup byte.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [1:0] {
        ST_RUN,
        ST_WAIT_BASE,
        ST_WAIT_CASC,
        ST_WAIT_MODE
    } init_state_t;

    localparam logic [2:0] OP_NS_EOI   = 3'b001;
    localparam logic [2:0] OP_SPEC_EOI = 3'b011;
endpackage

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
    import pic_pkg::*;
#(
    parameter int DW = 8,
    parameter int LW = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output init_state_t        state,
    output logic               running,
    output logic               start_hit,
    output logic               mask_wr,
    output logic               cmd_wr,
    output logic [DW-LW-1:0]   base_hi,
    output logic [DW-1:0]      casc_cfg,
    output logic               level_mode,
    output logic               auto_eoi
);
    init_state_t state_q, state_d;
    logic        need_mode_q;
    logic        skip_casc_q;
    logic        data_wr;

    assign data_wr   = bus_wr && bus_addr;
    assign start_hit = bus_wr && !bus_addr && bus_wdata[4];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (start_hit) begin
            state_d = ST_WAIT_BASE;
        end else if (data_wr) begin
            unique case (state_q)
                ST_RUN:       state_d = ST_RUN;
                ST_WAIT_BASE: state_d = !skip_casc_q ? ST_WAIT_CASC
                                      : (need_mode_q ? ST_WAIT_MODE : ST_RUN);
                ST_WAIT_CASC: state_d = need_mode_q ? ST_WAIT_MODE : ST_RUN;
                ST_WAIT_MODE: state_d = ST_RUN;
                default:      state_d = ST_RUN;
            endcase
        end
    end

    always_comb begin
        state   = state_q;
        running = (state_q == ST_RUN);
        mask_wr = data_wr && running;
        cmd_wr  = bus_wr && !bus_addr && !bus_wdata[4] && running;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            need_mode_q <= 1'b0;
            skip_casc_q <= 1'b0;
            base_hi     <= '0;
            casc_cfg    <= '0;
            level_mode  <= 1'b0;
            auto_eoi    <= 1'b0;
        end else if (start_hit) begin
            level_mode  <= bus_wdata[3];
            skip_casc_q <= bus_wdata[1];
            need_mode_q <= bus_wdata[0];
            auto_eoi    <= 1'b0;
        end else if (data_wr) begin
            unique case (state_q)
                ST_WAIT_BASE: base_hi  <= bus_wdata[DW-1:LW];
                ST_WAIT_CASC: casc_cfg <= bus_wdata;
                ST_WAIT_MODE: auto_eoi <= bus_wdata[1];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_all,
    input  logic         level_mode,
    input  logic [N-1:0] req_in,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] pending
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic prev_q;
        logic pend_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                prev_q <= req_in[i];
                if (clear_all || !req_in[i] || ack_clr[i]) pend_q <= 1'b0;
                else if (level_mode || !prev_q)            pend_q <= 1'b1;
            end
        end

        assign pending[i] = pend_q;
    end
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
    parameter int N  = 8,
    parameter int LW = 3
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  block,
    output logic          valid,
    output logic [LW-1:0] idx
);
    always_comb begin
        logic stop;
        stop  = 1'b0;
        valid = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (!stop) begin
                if (block[i]) begin
                    stop = 1'b1;
                end else if (req[i]) begin
                    valid = 1'b1;
                    idx   = LW'(i);
                    stop  = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
#(
    parameter int N_IN = 8,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic            bus_wr,
    input  logic            bus_rd,
    output logic [DW-1:0]   bus_rdata,
    input  logic [N_IN-1:0] irq_in,
    output logic            irq_out,
    input  logic            irq_ack,
    output logic            vec_valid,
    output logic [DW-1:0]   vec_out
);
    localparam int LW = $clog2(N_IN);

    init_state_t         init_state;
    logic                running, start_hit, mask_wr, cmd_wr;
    logic [DW-LW-1:0]    base_hi;
    logic [DW-1:0]       casc_cfg;
    logic                level_mode, auto_eoi;

    logic [N_IN-1:0]     mask_q, isr_q, isr_d, irr, ack_clr;
    logic                rd_isr_q;
    logic                win_valid, top_valid;
    logic [LW-1:0]       win_idx, top_idx;
    logic                ack_ok;
    logic [2:0]          op;

    pic_init_fsm #(.DW(DW), .LW(LW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .state(init_state), .running(running),
        .start_hit(start_hit), .mask_wr(mask_wr), .cmd_wr(cmd_wr),
        .base_hi(base_hi), .casc_cfg(casc_cfg), .level_mode(level_mode),
        .auto_eoi(auto_eoi)
    );

    pic_req_latch #(.N(N_IN)) u_req (
        .clk(clk), .rst_n(rst_n), .clear_all(start_hit),
        .level_mode(level_mode), .req_in(irq_in), .ack_clr(ack_clr),
        .pending(irr)
    );

    pic_prio #(.N(N_IN), .LW(LW)) u_win (
        .req(irr & ~mask_q), .block(isr_q), .valid(win_valid), .idx(win_idx)
    );

    pic_prio #(.N(N_IN), .LW(LW)) u_top (
        .req(isr_q), .block('0), .valid(top_valid), .idx(top_idx)
    );

    assign ack_ok  = irq_ack && running;
    assign ack_clr = (ack_ok && win_valid) ? (N_IN'(1) << win_idx) : '0;
    assign irq_out = running && win_valid;
    assign op      = bus_wdata[7:5];

    always_comb begin
        isr_d = isr_q;
        if (ack_ok && win_valid && !auto_eoi) isr_d[win_idx] = 1'b1;
        if (cmd_wr && !bus_wdata[3]) begin
            if (op == OP_SPEC_EOI)
                isr_d[bus_wdata[LW-1:0]] = 1'b0;
            else if (op == OP_NS_EOI && top_valid)
                isr_d[top_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '1;
            isr_q     <= '0;
            rd_isr_q  <= 1'b0;
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            vec_valid <= ack_ok;
            if (ack_ok)
                vec_out <= {base_hi, (win_valid ? win_idx : {LW{1'b1}})};
            if (start_hit) begin
                mask_q   <= '1;
                isr_q    <= '0;
                rd_isr_q <= 1'b0;
            end else begin
                isr_q <= isr_d;
                if (mask_wr) mask_q <= bus_wdata[N_IN-1:0];
                if (cmd_wr && bus_wdata[3] && bus_wdata[1])
                    rd_isr_q <= bus_wdata[0];
            end
        end
    end

    always_comb begin
        if (!bus_rd)       bus_rdata = '0;
        else if (bus_addr) bus_rdata = DW'(mask_q);
        else if (rd_isr_q) bus_rdata = DW'(isr_q);
        else               bus_rdata = DW'(irr);
    end
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk
    import pic_pkg::*;
#(
    parameter int N_IN = 8,
    parameter int DW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic            bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic            irq_ack,
    input logic            running,
    input logic            mask_wr,
    input logic            start_hit,
    input init_state_t     init_state,
    input logic [DW-1:0]   casc_cfg,
    input logic [N_IN-1:0] mask_q,
    input logic [N_IN-1:0] isr_q,
    input logic            win_valid,
    input logic            auto_eoi,
    input logic            vec_valid,
    input logic [DW-1:0]   vec_out
);
    localparam int LW = $clog2(N_IN);

    assert_vec_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && running) |=> vec_valid);

    assert_vec_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_ack |=> !vec_valid);

    assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_q == $past(bus_wdata[N_IN-1:0])));

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_hit |=> (mask_q == '1 && isr_q == '0));

    assert_casc_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (init_state == ST_WAIT_CASC && bus_wr && bus_addr && !start_hit)
        |=> (casc_cfg == $past(bus_wdata)));

    assert_one_new_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isr_q & ~$past(isr_q)));

    assert_auto_eoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && running && auto_eoi && !bus_wr) |=> $stable(isr_q));

    assert_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && running && !win_valid && !bus_wr)
        |=> (vec_out[LW-1:0] == {LW{1'b1}} && $stable(isr_q)));

    assert_no_vec_in_setup_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !running) |=> !vec_valid);
endmodule

bind pic_core pic_core_chk #(.N_IN(N_IN), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq_ack(irq_ack), .running(running),
    .mask_wr(mask_wr), .start_hit(start_hit), .init_state(init_state),
    .casc_cfg(casc_cfg), .mask_q(mask_q), .isr_q(isr_q),
    .win_valid(win_valid), .auto_eoi(auto_eoi), .vec_valid(vec_valid),
    .vec_out(vec_out)
);

// File: tb/sim_pic_core.sv
module sim_pic_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = '0;
    logic       irq_out;
    logic       irq_ack = 1'b0;
    logic       vec_valid;
    logic [7:0] vec_out;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    pic_core u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_out(irq_out), .irq_ack(irq_ack),
        .vec_valid(vec_valid), .vec_out(vec_out)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rdchk(string tag, logic a, logic [7:0] exp);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(tag, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    // driver: expected vector goes to the scoreboard, then the pulse
    task automatic ackx(logic [7:0] exp);
        exp_q.push_back(exp);
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    // monitor: compares every produced vector with the scoreboard
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_err++;
                $display("FAIL R3/R12 unexpected vector actual=%02h expected=none", vec_out);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (vec_out !== e) begin
                    n_err++;
                    $display("FAIL R3 vector actual=%02h expected=%02h", vec_out, e);
                end
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk("R1 irq_out", {7'd0, irq_out}, 8'h00);
        rdchk("R1 mask", 1'b1, 8'hFF);
        rdchk("R1 pending", 1'b0, 8'h00);

        // four-word setup, base 0x20, acknowledge attempted mid-setup
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h20);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        chk("R12 no vector in setup", {7'd0, vec_valid}, 8'h00);
        wr(1'b1, 8'h04);
        wr(1'b1, 8'h01);
        wr(1'b1, 8'h00);
        rdchk("R4 mask readback", 1'b1, 8'h00);

        irq_in[5] = 1'b1; settle();
        chk("R11 edge raises irq_out", {7'd0, irq_out}, 8'h01);
        rdchk("R6 default pending readback", 1'b0, 8'h20);
        ackx(8'h25);
        wr(1'b0, 8'h0B);
        rdchk("R6 in-service readback", 1'b0, 8'h20);
        chk("R11 held edge not re-requested", {7'd0, irq_out}, 8'h00);

        irq_in[6] = 1'b1; settle();
        chk("R5 lower level blocked", {7'd0, irq_out}, 8'h00);
        irq_in[2] = 1'b1; settle();
        chk("R5 higher level forwarded", {7'd0, irq_out}, 8'h01);
        ackx(8'h22);
        rdchk("R5 nested service", 1'b0, 8'h24);

        wr(1'b0, 8'h65);
        rdchk("R7 specific end", 1'b0, 8'h04);
        chk("R5 level 6 still blocked", {7'd0, irq_out}, 8'h00);
        wr(1'b0, 8'h20);
        rdchk("R8 non-specific end", 1'b0, 8'h00);
        chk("R8 level 6 released", {7'd0, irq_out}, 8'h01);
        wr(1'b0, 8'h0A);
        rdchk("R11 pending after acks", 1'b0, 8'h40);

        wr(1'b1, 8'h40);
        chk("R4 masked input", {7'd0, irq_out}, 8'h00);
        rdchk("R4 mask value", 1'b1, 8'h40);

        // vanished request with level 7 masked
        wr(1'b1, 8'h80);
        chk("R4 unmasked input", {7'd0, irq_out}, 8'h01);
        irq_in[6] = 1'b0; settle();
        chk("R10 request gone", {7'd0, irq_out}, 8'h00);
        ackx(8'h27);
        wr(1'b0, 8'h0B);
        rdchk("R10 no service set", 1'b0, 8'h00);

        irq_in = '0; settle();
        irq_in[0] = 1'b1; settle();
        ackx(8'h20);
        rdchk("R3 level 0 in service", 1'b0, 8'h01);

        // re-setup as automatic end, base 0x28
        wr(1'b0, 8'h11);
        rdchk("R2 mask set by start", 1'b1, 8'hFF);
        wr(1'b1, 8'h28);
        wr(1'b1, 8'h02);
        wr(1'b1, 8'h03);
        wr(1'b0, 8'h0B);
        rdchk("R2 service cleared", 1'b0, 8'h00);
        wr(1'b1, 8'h00);
        chk("R11 held line needs new edge", {7'd0, irq_out}, 8'h00);
        irq_in[3] = 1'b1; settle();
        ackx(8'h2B);
        rdchk("R9 auto end leaves service empty", 1'b0, 8'h00);
        chk("R9 no re-request", {7'd0, irq_out}, 8'h00);

        // short setup: level sensing, no cascade or mode word
        irq_in[0] = 1'b0;
        wr(1'b0, 8'h1A);
        wr(1'b1, 8'h40);
        wr(1'b1, 8'h00);
        rdchk("R2 skipped words, mask loaded", 1'b1, 8'h00);
        settle();
        chk("R11 level request", {7'd0, irq_out}, 8'h01);
        ackx(8'h43);
        wr(1'b0, 8'h0B);
        rdchk("R9 auto end off", 1'b0, 8'h08);
        wr(1'b0, 8'h20);
        rdchk("R8 end in level mode", 1'b0, 8'h00);
        chk("R11 level re-request", {7'd0, irq_out}, 8'h01);

        irq_in = '0;
        repeat (3) settle();
        chk("R3 scoreboard drained", 8'(exp_q.size()), 8'h00);
        finish_run();
    end
endmodule